// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block steps a processor through one bus cycle on a bus where address and data share the same pins. The processor raises its address strobe while the logical address is on the pins. When a translation unit is present, a translation phase follows. It lasts until the translation unit pulses its physical-address-valid line, and that pulse, not the processor's strobe, acts as the system address strobe. The sequencer then enters the data phase and drives a read or a write strobe. It stretches that phase with wait states while a ready/wait input holds it off. It closes with a quiet final phase and a cycle-done flag.

On the accepted system strobe, the physical address is captured from the shared pins into a register. The memory decoder can therefore use it after the pins have turned around to carry data. The transfer direction is captured when the processor's strobe is accepted. A build parameter removes the translation phase. In that variant the processor's strobe is itself the system strobe, and the cycle moves from the address phase straight to the data phase.

Top module: `bus_cycle_seq`

## Requirements
- R1: After reset, `phase_o` is 0 (idle), `rd_o`, `wr_o`, `done_o` and `sys_as_o` are low, and `phys_addr_o` is 0.
- R2: A processor strobe seen in the idle phase moves `phase_o` to 1 (address phase) on the next clock. A strobe seen in any other phase is ignored and does not disturb the running cycle.
- R3: With translation enabled, the address phase is followed by the translation phase (`phase_o` = 2). The sequencer stays there until `pav_i` is seen, then moves to the first data phase (`phase_o` = 3). `sys_as_o` is high during exactly the cycle in which `pav_i` is accepted.
- R4: On the accepted system strobe, `phys_addr_o` loads the value on `ad_bus_i`. It then holds that value until the next accepted system strobe.
- R5: In the data phases (`phase_o` 3, 4, 5), `rd_o` is high for a read (`dir_rd_i` = 1) and `wr_o` is high for a write. The two strobes are never high together, and both are low in phases 0, 1, 2 and 6.
- R6: If `wait_i` is high in phase 3 or phase 4, the next phase is 4 (wait state). If it is low, the next phase is 5.
- R7: Phase 5 is followed by phase 6 and then by idle. `done_o` is high exactly in phase 6.
- R8: With translation disabled, a processor strobe in idle drives `sys_as_o` high in the same cycle and loads the address into `phys_addr_o`. The address phase then goes directly to phase 3.
- R9: The direction is sampled only when the processor's strobe is accepted. Later changes of `dir_rd_i` within the cycle do not change which strobe is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ads_i | input | 1 | Processor address strobe, one-cycle pulse |
| pav_i | input | 1 | Physical-address-valid pulse from the translation unit |
| dir_rd_i | input | 1 | Transfer direction, 1 = read, 0 = write |
| ad_bus_i | input | BUS_W | Shared address/data pins as seen by the sequencer |
| wait_i | input | 1 | Ready/wait request, 1 = insert wait state |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | Write strobe |
| sys_as_o | output | 1 | System address strobe (accepted address-valid event) |
| phys_addr_o | output | BUS_W | Captured physical address |
| done_o | output | 1 | Cycle-done flag, high in the final phase |
| phase_o | output | 3 | Current phase: 0 idle, 1 address, 2 translation, 3 first data, 4 wait, 5 second data, 6 final |

## Verification
The hardest situations to reach from the ports depend on what the pins and the direction input do after the cycle has started. One is a processor strobe arriving in the middle of a data phase. Another is the shared pins changing from logical to physical address during translation. A third is the direction input flipping after it was sampled. Each directed cycle therefore changes the pins to a new address and inverts `dir_rd_i` right after the address phase. It holds `pav_i` off for a chosen number of cycles and raises `ads_i` again during the second data phase. It then checks the strobe, the phase and the captured address on every cycle. A second instance built without translation runs the same style of cycles to cover the direct path.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_ADDR = 3'd1,
        PH_XLAT = 3'd2,
        PH_DAT1 = 3'd3,
        PH_WAIT = 3'd4,
        PH_DAT2 = 3'd5,
        PH_FIN  = 3'd6
    } phase_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic done;
    } strobe_t;

    function automatic logic in_data(phase_e ph);
        return (ph == PH_DAT1) || (ph == PH_WAIT) || (ph == PH_DAT2);
    endfunction

    function automatic phase_e step(phase_e cur, logic ads, logic pav,
                                    logic wt, logic xlat);
        phase_e nx;
        case (cur)
            PH_IDLE: nx = ads ? PH_ADDR : PH_IDLE;
            PH_ADDR: nx = xlat ? PH_XLAT : PH_DAT1;
            PH_XLAT: nx = pav ? PH_DAT1 : PH_XLAT;
            PH_DAT1,
            PH_WAIT: nx = wt ? PH_WAIT : PH_DAT2;
            PH_DAT2: nx = PH_FIN;
            PH_FIN:  nx = PH_IDLE;
            default: nx = PH_IDLE;
        endcase
        return nx;
    endfunction

endpackage

// File: rtl/bcs_phase_fsm.sv
module bcs_phase_fsm
    import bcs_pkg::*;
#(
    parameter bit XLAT_EN = 1'b1
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   ads_i,
    input  logic   pav_i,
    input  logic   wait_i,
    output phase_e phase_o,
    output logic   start_o,
    output logic   accept_o
);
    phase_e cur_q;

    always_ff @(posedge clk) begin
        if (rst) cur_q <= PH_IDLE;
        else     cur_q <= step(cur_q, ads_i, pav_i, wait_i, XLAT_EN);
    end

    assign phase_o = cur_q;
    assign start_o = (cur_q == PH_IDLE) && ads_i;

    generate
        if (XLAT_EN) begin : g_xlat
            assign accept_o = (cur_q == PH_XLAT) && pav_i;
        end else begin : g_direct
            assign accept_o = start_o;
        end
    endgenerate

    // R2
    addr_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_q != PH_IDLE) |=> (cur_q != PH_ADDR));

    // R6
    wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((cur_q == PH_DAT1 || cur_q == PH_WAIT) && wait_i) |=> (cur_q == PH_WAIT));

    // R7
    tail_order_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_q == PH_DAT2) |=> (cur_q == PH_FIN));

    // R3
    xlat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_q == PH_XLAT && !pav_i) |=> (cur_q == PH_XLAT));
endmodule

// File: rtl/bcs_addr_latch.sv
module bcs_addr_latch #(
    parameter int BUS_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             cap_i,
    input  logic             dir_rd_i,
    input  logic [BUS_W-1:0] bus_i,
    output logic             is_read_o,
    output logic [BUS_W-1:0] phys_o
);
    logic [BUS_W-1:0] addr_q;
    logic             rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            rd_q   <= 1'b0;
        end else begin
            if (cap_i)   addr_q <= bus_i;
            if (start_i) rd_q   <= dir_rd_i;
        end
    end

    assign phys_o    = addr_q;
    assign is_read_o = rd_q;

    // R4
    addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !cap_i |=> $stable(addr_q));

    // R9
    dir_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> $stable(rd_q));
endmodule

// File: rtl/bcs_strobe_gen.sv
module bcs_strobe_gen
    import bcs_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  phase_e  phase_i,
    input  logic    is_read_i,
    output strobe_t stb_o
);
    always_comb begin
        stb_o.rd   = in_data(phase_i) && is_read_i;
        stb_o.wr   = in_data(phase_i) && !is_read_i;
        stb_o.done = (phase_i == PH_FIN);
    end

    // R5
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(stb_o.rd && stb_o.wr));

    // R7
    done_then_idle_chk: assert property (@(posedge clk) disable iff (rst)
        stb_o.done |=> (phase_i == PH_IDLE));

    // R5
    strobe_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_i == PH_DAT2) |=> !(stb_o.rd || stb_o.wr));
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
    import bcs_pkg::*;
#(
    parameter int BUS_W   = 24,
    parameter bit XLAT_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ads_i,
    input  logic             pav_i,
    input  logic             dir_rd_i,
    input  logic [BUS_W-1:0] ad_bus_i,
    input  logic             wait_i,
    output logic             rd_o,
    output logic             wr_o,
    output logic             sys_as_o,
    output logic [BUS_W-1:0] phys_addr_o,
    output logic             done_o,
    output logic [2:0]       phase_o
);
    phase_e  phase;
    logic    start;
    logic    accept;
    logic    is_read;
    strobe_t stb;

    bcs_phase_fsm #(.XLAT_EN(XLAT_EN)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .ads_i   (ads_i),
        .pav_i   (pav_i),
        .wait_i  (wait_i),
        .phase_o (phase),
        .start_o (start),
        .accept_o(accept)
    );

    bcs_addr_latch #(.BUS_W(BUS_W)) u_latch (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start),
        .cap_i    (accept),
        .dir_rd_i (dir_rd_i),
        .bus_i    (ad_bus_i),
        .is_read_o(is_read),
        .phys_o   (phys_addr_o)
    );

    bcs_strobe_gen u_stb (
        .clk      (clk),
        .rst      (rst),
        .phase_i  (phase),
        .is_read_i(is_read),
        .stb_o    (stb)
    );

    assign rd_o     = stb.rd;
    assign wr_o     = stb.wr;
    assign done_o   = stb.done;
    assign sys_as_o = accept;
    assign phase_o  = phase;

    // R8
    sys_as_entry_chk: assert property (@(posedge clk) disable iff (rst)
        sys_as_o |=> (phase_o == 3'd1 || phase_o == 3'd3));
endmodule

// File: tb/bus_cycle_seq_bench.sv
`timescale 1ns/1ps
module bus_cycle_seq_bench;
    localparam int BW = 24;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic          ads = 0, pav = 0, dir = 0, wt = 0;
    logic [BW-1:0] bus = '0;
    logic          rd, wr, sas, done;
    logic [BW-1:0] pa;
    logic [2:0]    ph;

    logic          d_ads = 0, d_dir = 0, d_wt = 0;
    logic [BW-1:0] d_bus = '0;
    logic          d_rd, d_wr, d_sas, d_done;
    logic [BW-1:0] d_pa;
    logic [2:0]    d_ph;

    bus_cycle_seq #(.BUS_W(BW), .XLAT_EN(1'b1)) u_bus_cycle_seq (
        .clk(clk), .rst(rst), .ads_i(ads), .pav_i(pav), .dir_rd_i(dir),
        .ad_bus_i(bus), .wait_i(wt), .rd_o(rd), .wr_o(wr), .sys_as_o(sas),
        .phys_addr_o(pa), .done_o(done), .phase_o(ph));

    bus_cycle_seq #(.BUS_W(BW), .XLAT_EN(1'b0)) u_bus_cycle_seq_direct (
        .clk(clk), .rst(rst), .ads_i(d_ads), .pav_i(1'b0), .dir_rd_i(d_dir),
        .ad_bus_i(d_bus), .wait_i(d_wt), .rd_o(d_rd), .wr_o(d_wr), .sys_as_o(d_sas),
        .phys_addr_o(d_pa), .done_o(d_done), .phase_o(d_ph));

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk(ph == 3'd0, "R1 phase", ph, 0);
        chk(!rd && !wr && !done && !sas, "R1 strobes", {rd, wr, done, sas}, 0);
        chk(pa == '0, "R1 addr", pa, 0);
        chk(d_ph == 3'd0 && d_pa == '0, "R1 direct", d_ph, 0);
    endtask

    task automatic t_xlat_cycle(input bit is_rd, input logic [BW-1:0] la,
                                input logic [BW-1:0] phys, input int xdly, input int nw);
        logic [BW-1:0] prev = pa;
        ads = 1; bus = la; dir = is_rd;
        tick();
        ads = 0; dir = ~is_rd; bus = phys;       // R9 direction flips after sampling
        chk(ph == 3'd1, "R2 addr phase", ph, 1);
        chk(!rd && !wr, "R5 quiet in addr", {rd, wr}, 0);
        chk(pa == prev, "R4 hold before pav", pa, prev);
        tick();
        chk(ph == 3'd2, "R3 xlat phase", ph, 2);
        for (int i = 0; i < xdly; i++) begin
            chk(!sas && !rd && !wr, "R3 no strobe while xlat", {sas, rd, wr}, 0);
            tick();
            chk(ph == 3'd2, "R3 xlat hold", ph, 2);
        end
        pav = 1;
        #0.1;
        chk(sas == 1'b1, "R3 sys strobe", sas, 1);
        tick();
        pav = 0; bus = ~phys;                    // pins now carry data
        chk(ph == 3'd3, "R3 data entry", ph, 3);
        chk(pa == phys, "R4 captured", pa, phys);
        chk(rd == is_rd && wr == !is_rd, "R9 R5 strobe dir", {rd, wr}, {is_rd, !is_rd});
        for (int i = 0; i < nw; i++) begin
            wt = 1;
            tick();
            chk(ph == 3'd4, "R6 wait state", ph, 4);
            chk(rd == is_rd && wr == !is_rd, "R5 strobe in wait", {rd, wr}, {is_rd, !is_rd});
        end
        wt = 0;
        tick();
        chk(ph == 3'd5, "R6 leave to T3", ph, 5);
        chk(rd == is_rd && wr == !is_rd, "R5 strobe in T3", {rd, wr}, {is_rd, !is_rd});
        ads = 1;                                  // R2 strobe mid-cycle ignored
        tick();
        ads = 0;
        chk(ph == 3'd6, "R7 final phase", ph, 6);
        chk(done && !rd && !wr, "R7 done R5 quiet", {done, rd, wr}, 3'b100);
        tick();
        chk(ph == 3'd0 && !done, "R2 R7 back to idle", {ph, done}, 0);
        chk(pa == phys, "R4 hold after cycle", pa, phys);
    endtask

    task automatic t_direct_cycle(input bit is_rd, input logic [BW-1:0] a, input int nw);
        d_ads = 1; d_bus = a; d_dir = is_rd;
        #0.1;
        chk(d_sas == 1'b1, "R8 direct sys strobe", d_sas, 1);
        tick();
        d_ads = 0; d_dir = ~is_rd; d_bus = ~a;
        chk(d_ph == 3'd1 && d_pa == a, "R8 direct capture", d_pa, a);
        tick();
        chk(d_ph == 3'd3, "R8 direct skips xlat", d_ph, 3);
        chk(d_rd == is_rd && d_wr == !is_rd, "R9 direct dir", {d_rd, d_wr}, {is_rd, !is_rd});
        for (int i = 0; i < nw; i++) begin
            d_wt = 1;
            tick();
            chk(d_ph == 3'd4, "R6 direct wait", d_ph, 4);
        end
        d_wt = 0;
        tick();
        chk(d_ph == 3'd5, "R6 direct T3", d_ph, 5);
        tick();
        chk(d_ph == 3'd6 && d_done, "R7 direct done", {d_ph, d_done}, 4'hd);
        tick();
        chk(d_ph == 3'd0 && d_pa == a, "R4 direct hold", d_pa, a);
    endtask

    initial begin
        repeat (3) tick();
        rst = 0;
        tick();
        t_reset();
        t_xlat_cycle(1'b1, 24'h012345, 24'h8a0010, 0, 0);
        t_xlat_cycle(1'b0, 24'h00fffe, 24'h1c2222, 3, 2);
        t_xlat_cycle(1'b1, 24'hffffff, 24'h000000, 1, 5);
        t_xlat_cycle(1'b0, 24'h5a5a5a, 24'ha5a5a5, 6, 1);
        t_direct_cycle(1'b1, 24'h123456, 0);
        t_direct_cycle(1'b0, 24'hfedcba, 3);
        tick();
        chk(ph == 3'd0 && !rd && !wr, "R5 idle quiet", {ph, rd, wr}, 0);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #100000;
        n_bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule